// File: doc/BRIEF.md
# SDRAM Command Legality Tracker

This block listens to the decoded command pins of a four-bank double-data-rate SDRAM device and keeps a shadow of the state the device is in. For each bank it tracks whether the bank is idle, opening a row, holding an open row, running a read burst, running a write burst, or closing its row. At the device level it also tracks the mode-register window, auto refresh, self refresh with its exit window, and power down.

Each cycle the block looks at the command on the pins together with the shadow state. It gives a verdict on that command: the command is accepted and changes state, it is harmless and changes nothing, or it is not allowed in the current state. An accepted command moves the shadow state at the next clock edge. A command that is not allowed moves nothing. The timed windows end by themselves after parameterised cycle counts, so the new bank and device states show up on the state outputs as soon as the device itself would reach them.

The block is meant to sit beside a memory controller or a bus model as a protocol monitor. The verdict output flags sequencing errors, and the state outputs show what the device should be doing.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Commands are taken from {cs_n,ras_n,cas_n,we_n}. With cs_n=1 the command is deselect. With cs_n=0, {ras_n,cas_n,we_n} decodes as follows: 111 no-op, 110 burst stop, 101 read, 100 write, 011 activate, 010 precharge, 001 refresh, 000 mode set. After reset every bank field reads 0 (idle) and the device state reads 0 (normal). Bank field codes are 0 idle, 1 opening, 2 open, 3 reading, 4 writing, 5 closing. Bank b uses bits [3b+2:3b] of bank_state_o. Device codes are 0 normal, 1 mode window, 2 refresh, 3 self refresh, 4 self-refresh exit, 5 power down.
- R2: The verdict is combinational on the current pins and state. Its codes are 0 no effect, 1 accepted, 2 not allowed, and it never takes the value 3. In the normal state with cke high, deselect and no-op give 0.
- R3: An activate to an idle bank is accepted and puts the bank in state 1. A command issued T_RCD cycles after the activate sees state 2. Any command other than deselect or no-op that targets the bank while it is opening is not allowed. An activate to a bank that is not idle is not allowed.
- R4: A read is accepted only when the target bank is open or reading, and a write only when it is open or writing. The burst state lasts BURST_CYC cycles. After that the bank returns to open, or, if a8 was 1 on the command, it goes to closing for T_RP cycles and then to idle.
- R5: A precharge with a8=0 gives 0 on an idle bank. On an open, reading or writing bank it is accepted, which ends any burst, and the bank goes to closing for T_RP cycles and then to idle. On an opening or closing bank it is not allowed.
- R6: A precharge with a8=1 covers all banks. It is not allowed while any bank is opening or closing. It gives 0 when all banks are idle. Otherwise it is accepted and every non-idle bank goes to closing.
- R7: A burst stop is accepted only while some bank is reading, and it returns every reading bank to open. With no bank reading it is not allowed.
- R8: A mode set is accepted only with all banks idle. It opens the mode window for T_MRD cycles. Inside the window every command other than deselect or no-op is not allowed.
- R9: A refresh with cke high is accepted only with all banks idle. It opens the refresh window for T_RFC cycles, with the same rule inside the window as in R8.
- R10: A refresh code on the cycle where cke falls (high on the previous cycle, low now), with all banks idle, is accepted and enters self refresh. Inside self refresh, deselect or no-op with cke low gives 0, and everything else with cke low is not allowed. Deselect or no-op with cke high is accepted and starts the exit window, which ends after T_XSR cycles. Inside the exit window only deselect or no-op is allowed.
- R11: Deselect or no-op on a falling cke with all banks idle is accepted and enters power down. There, deselect or no-op with cke low gives 0, and deselect or no-op with cke high is accepted and returns at once to normal. A falling cke while any bank is not idle is not allowed.
- R12: A command that is not allowed changes no bank state and no device state, apart from windows that are already running down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin as seen by the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a8 | input | 1 | Address bit 8: auto-precharge or all-bank flag |
| verdict_o | output | 2 | Verdict on the current command (R2 codes) |
| bank_state_o | output | 12 | Packed per-bank states, 3 bits per bank |
| glob_state_o | output | 3 | Device-level state (R1 codes) |

## Verification
Directed sequences drive each command into every state where it matters. Each command is tried once too early and once exactly at the end of a timed window, which pins down the cycle count of the opening, burst, closing, mode, refresh and exit windows. Each command is also tried against banks in different states, which separates targeted checks from all-bank checks (single versus all-bank precharge, activate to a second bank while the first is still opening). The cke edge patterns separate self-refresh entry from power-down entry and exit from staying asleep. After every rejected command the state outputs are read back to show that nothing moved.

// File: rtl/sdcl_pkg.sv
`timescale 1ns/1ps
package sdcl_pkg;

   typedef enum logic [3:0] {
      CMD_DSEL, CMD_NOP, CMD_BST, CMD_RD, CMD_WR,
      CMD_ACT, CMD_PRE, CMD_REF, CMD_MRS
   } cmd_e;

   typedef enum logic [2:0] {
      BK_IDLE = 3'd0, BK_OPEN = 3'd1, BK_ACTV = 3'd2,
      BK_RD   = 3'd3, BK_WR   = 3'd4, BK_PCHG = 3'd5
   } bank_st_e;

   typedef enum logic [2:0] {
      GL_NORM  = 3'd0, GL_MODE = 3'd1, GL_RFSH = 3'd2,
      GL_SLEEP = 3'd3, GL_WAKE = 3'd4, GL_PDN  = 3'd5
   } glob_st_e;

   typedef enum logic [1:0] {
      VD_NOP = 2'd0, VD_OK = 2'd1, VD_BAD = 2'd2
   } verdict_e;

   typedef enum logic [2:0] {
      BA_HOLD, BA_OPEN, BA_RD, BA_WR, BA_PRE, BA_STOP
   } bank_act_e;

   typedef enum logic [2:0] {
      GA_NONE, GA_MODE, GA_RFSH, GA_SLEEP, GA_WAKE, GA_PDN_IN, GA_PDN_OUT
   } glob_act_e;

endpackage

// File: rtl/sdcl_decode.sv
`timescale 1ns/1ps
module sdcl_decode
   import sdcl_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd_o
);

   always_comb begin
      if (cs_n) begin
         cmd_o = CMD_DSEL;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b111:  cmd_o = CMD_NOP;
            3'b110:  cmd_o = CMD_BST;
            3'b101:  cmd_o = CMD_RD;
            3'b100:  cmd_o = CMD_WR;
            3'b011:  cmd_o = CMD_ACT;
            3'b010:  cmd_o = CMD_PRE;
            3'b001:  cmd_o = CMD_REF;
            default: cmd_o = CMD_MRS;
         endcase
      end
   end

endmodule

// File: rtl/sdcl_judge.sv
`timescale 1ns/1ps
module sdcl_judge
   import sdcl_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   localparam int BA_W = $clog2(NUM_BANKS)
) (
   input  cmd_e            cmd_i,
   input  logic            cke_i,
   input  logic            cke_q_i,
   input  logic [BA_W-1:0] ba_i,
   input  logic            a8_i,
   input  bank_st_e        bst_i [NUM_BANKS],
   input  glob_st_e        gst_i,
   output verdict_e        vd_o,
   output bank_act_e       bact_o [NUM_BANKS],
   output glob_act_e       gact_o
);

   logic     all_idle, any_busy, any_rd, nopish;
   bank_st_e tgt;

   always_comb begin
      all_idle = 1'b1;
      any_busy = 1'b0;
      any_rd   = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bst_i[b] != BK_IDLE) all_idle = 1'b0;
         if (bst_i[b] == BK_OPEN || bst_i[b] == BK_PCHG) any_busy = 1'b1;
         if (bst_i[b] == BK_RD) any_rd = 1'b1;
      end
   end

   assign tgt    = bst_i[ba_i];
   assign nopish = (cmd_i == CMD_DSEL) || (cmd_i == CMD_NOP);

   always_comb begin
      vd_o   = VD_NOP;
      gact_o = GA_NONE;
      for (int b = 0; b < NUM_BANKS; b++) bact_o[b] = BA_HOLD;
      case (gst_i)
         GL_SLEEP, GL_PDN: begin
            if (nopish && cke_i) begin
               vd_o   = VD_OK;
               gact_o = (gst_i == GL_SLEEP) ? GA_WAKE : GA_PDN_OUT;
            end else if (nopish) begin
               vd_o = VD_NOP;
            end else begin
               vd_o = VD_BAD;
            end
         end
         GL_MODE, GL_RFSH, GL_WAKE: begin
            vd_o = (nopish && cke_i) ? VD_NOP : VD_BAD;
         end
         default: begin
            if (!cke_i) begin
               if (cke_q_i && all_idle && cmd_i == CMD_REF) begin
                  vd_o   = VD_OK;
                  gact_o = GA_SLEEP;
               end else if (cke_q_i && all_idle && nopish) begin
                  vd_o   = VD_OK;
                  gact_o = GA_PDN_IN;
               end else begin
                  vd_o = VD_BAD;
               end
            end else begin
               case (cmd_i)
                  CMD_DSEL, CMD_NOP: vd_o = VD_NOP;
                  CMD_ACT: begin
                     if (tgt == BK_IDLE) begin
                        vd_o         = VD_OK;
                        bact_o[ba_i] = BA_OPEN;
                     end else vd_o = VD_BAD;
                  end
                  CMD_RD: begin
                     if (tgt == BK_ACTV || tgt == BK_RD) begin
                        vd_o         = VD_OK;
                        bact_o[ba_i] = BA_RD;
                     end else vd_o = VD_BAD;
                  end
                  CMD_WR: begin
                     if (tgt == BK_ACTV || tgt == BK_WR) begin
                        vd_o         = VD_OK;
                        bact_o[ba_i] = BA_WR;
                     end else vd_o = VD_BAD;
                  end
                  CMD_PRE: begin
                     if (!a8_i) begin
                        if (tgt == BK_IDLE) begin
                           vd_o = VD_NOP;
                        end else if (tgt == BK_ACTV || tgt == BK_RD || tgt == BK_WR) begin
                           vd_o         = VD_OK;
                           bact_o[ba_i] = BA_PRE;
                        end else vd_o = VD_BAD;
                     end else if (any_busy) begin
                        vd_o = VD_BAD;
                     end else if (all_idle) begin
                        vd_o = VD_NOP;
                     end else begin
                        vd_o = VD_OK;
                        for (int b = 0; b < NUM_BANKS; b++)
                           if (bst_i[b] != BK_IDLE) bact_o[b] = BA_PRE;
                     end
                  end
                  CMD_REF: begin
                     if (all_idle) begin
                        vd_o   = VD_OK;
                        gact_o = GA_RFSH;
                     end else vd_o = VD_BAD;
                  end
                  CMD_MRS: begin
                     if (all_idle) begin
                        vd_o   = VD_OK;
                        gact_o = GA_MODE;
                     end else vd_o = VD_BAD;
                  end
                  CMD_BST: begin
                     if (any_rd) begin
                        vd_o = VD_OK;
                        for (int b = 0; b < NUM_BANKS; b++)
                           if (bst_i[b] == BK_RD) bact_o[b] = BA_STOP;
                     end else vd_o = VD_BAD;
                  end
                  default: vd_o = VD_BAD;
               endcase
            end
         end
      endcase
   end

endmodule

// File: rtl/sdcl_bank.sv
`timescale 1ns/1ps
module sdcl_bank
   import sdcl_pkg::*;
#(
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int BURST_CYC = 4,
   localparam int T_MAX = (T_RCD > T_RP) ? ((T_RCD > BURST_CYC) ? T_RCD : BURST_CYC)
                                         : ((T_RP > BURST_CYC) ? T_RP : BURST_CYC),
   localparam int CW = $clog2(T_MAX + 1)
) (
   input  logic      clk,
   input  logic      rst_n,
   input  bank_act_e act_i,
   input  logic      ap_i,
   output bank_st_e  st_o
);

   localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 2);
   localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 2);
   localparam logic [CW-1:0] LD_BST = CW'(BURST_CYC - 2);

   bank_st_e      st;
   logic [CW-1:0] cnt;
   logic          ap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= BK_IDLE;
         cnt  <= '0;
         ap_q <= 1'b0;
      end else begin
         case (st)
            BK_IDLE: begin
               if (act_i == BA_OPEN) begin
                  st  <= BK_OPEN;
                  cnt <= LD_RCD;
               end
            end
            BK_OPEN: begin
               if (cnt == '0) st <= BK_ACTV;
               else cnt <= cnt - CW'(1);
            end
            BK_ACTV, BK_RD, BK_WR: begin
               if (act_i == BA_RD) begin
                  st   <= BK_RD;
                  cnt  <= LD_BST;
                  ap_q <= ap_i;
               end else if (act_i == BA_WR) begin
                  st   <= BK_WR;
                  cnt  <= LD_BST;
                  ap_q <= ap_i;
               end else if (act_i == BA_PRE) begin
                  st  <= BK_PCHG;
                  cnt <= LD_RP;
               end else if (act_i == BA_STOP) begin
                  st <= BK_ACTV;
               end else if (st != BK_ACTV) begin
                  if (cnt == '0) begin
                     if (ap_q) begin
                        st  <= BK_PCHG;
                        cnt <= LD_RP;
                     end else begin
                        st <= BK_ACTV;
                     end
                  end else begin
                     cnt <= cnt - CW'(1);
                  end
               end
            end
            BK_PCHG: begin
               if (cnt == '0) st <= BK_IDLE;
               else cnt <= cnt - CW'(1);
            end
            default: st <= BK_IDLE;
         endcase
      end
   end

   assign st_o = st;

endmodule

// File: rtl/sdcl_glob.sv
`timescale 1ns/1ps
module sdcl_glob
   import sdcl_pkg::*;
#(
   parameter int T_MRD = 2,
   parameter int T_RFC = 6,
   parameter int T_XSR = 4,
   localparam int T_MAX = (T_MRD > T_RFC) ? ((T_MRD > T_XSR) ? T_MRD : T_XSR)
                                         : ((T_RFC > T_XSR) ? T_RFC : T_XSR),
   localparam int CW = $clog2(T_MAX + 1)
) (
   input  logic      clk,
   input  logic      rst_n,
   input  glob_act_e act_i,
   output glob_st_e  st_o
);

   localparam logic [CW-1:0] LD_MRD = CW'(T_MRD - 2);
   localparam logic [CW-1:0] LD_RFC = CW'(T_RFC - 2);
   localparam logic [CW-1:0] LD_XSR = CW'(T_XSR - 2);

   glob_st_e      st;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= GL_NORM;
         cnt <= '0;
      end else begin
         case (st)
            GL_NORM: begin
               case (act_i)
                  GA_MODE:   begin st <= GL_MODE; cnt <= LD_MRD; end
                  GA_RFSH:   begin st <= GL_RFSH; cnt <= LD_RFC; end
                  GA_SLEEP:  st <= GL_SLEEP;
                  GA_PDN_IN: st <= GL_PDN;
                  default:   st <= GL_NORM;
               endcase
            end
            GL_MODE, GL_RFSH, GL_WAKE: begin
               if (cnt == '0) st <= GL_NORM;
               else cnt <= cnt - CW'(1);
            end
            GL_SLEEP: begin
               if (act_i == GA_WAKE) begin
                  st  <= GL_WAKE;
                  cnt <= LD_XSR;
               end
            end
            GL_PDN: begin
               if (act_i == GA_PDN_OUT) st <= GL_NORM;
            end
            default: st <= GL_NORM;
         endcase
      end
   end

   assign st_o = st;

endmodule

// File: rtl/sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sdram_cmd_tracker
   import sdcl_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int T_MRD     = 2,
   parameter int T_RFC     = 6,
   parameter int T_XSR     = 4,
   parameter int BURST_CYC = 4,
   localparam int BA_W = $clog2(NUM_BANKS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cke,
   input  logic                   cs_n,
   input  logic                   ras_n,
   input  logic                   cas_n,
   input  logic                   we_n,
   input  logic [BA_W-1:0]        ba,
   input  logic                   a8,
   output logic [1:0]             verdict_o,
   output logic [3*NUM_BANKS-1:0] bank_state_o,
   output logic [2:0]             glob_state_o
);

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (T_RCD < 2 || T_RP < 2 || BURST_CYC < 2) begin : g_bad_bank_timer
      $error("bank timers must be at least 2 cycles");
   end
   if (T_MRD < 2 || T_RFC < 2 || T_XSR < 2) begin : g_bad_glob_timer
      $error("device timers must be at least 2 cycles");
   end

   cmd_e      cmd;
   logic      cke_q;
   verdict_e  vd;
   glob_act_e gact;
   glob_st_e  gst;
   bank_act_e bact [NUM_BANKS];
   bank_st_e  bst  [NUM_BANKS];

   always_ff @(posedge clk) begin
      if (!rst_n) cke_q <= 1'b1;
      else        cke_q <= cke;
   end

   sdcl_decode dec_i (
      .cs_n (cs_n),
      .ras_n(ras_n),
      .cas_n(cas_n),
      .we_n (we_n),
      .cmd_o(cmd)
   );

   sdcl_judge #(.NUM_BANKS(NUM_BANKS)) judge_i (
      .cmd_i  (cmd),
      .cke_i  (cke),
      .cke_q_i(cke_q),
      .ba_i   (ba),
      .a8_i   (a8),
      .bst_i  (bst),
      .gst_i  (gst),
      .vd_o   (vd),
      .bact_o (bact),
      .gact_o (gact)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      sdcl_bank #(.T_RCD(T_RCD), .T_RP(T_RP), .BURST_CYC(BURST_CYC)) bank_i (
         .clk  (clk),
         .rst_n(rst_n),
         .act_i(bact[b]),
         .ap_i (a8),
         .st_o (bst[b])
      );
      assign bank_state_o[3*b +: 3] = bst[b];
   end

   sdcl_glob #(.T_MRD(T_MRD), .T_RFC(T_RFC), .T_XSR(T_XSR)) glob_i (
      .clk  (clk),
      .rst_n(rst_n),
      .act_i(gact),
      .st_o (gst)
   );

   assign verdict_o    = vd;
   assign glob_state_o = gst;

endmodule

// File: rtl/sdcl_chk.sv
`timescale 1ns/1ps
module sdcl_chk #(
   parameter int NUM_BANKS = 4,
   parameter int T_RCD     = 3,
   localparam int BA_W = $clog2(NUM_BANKS)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cke,
   input logic                   cs_n,
   input logic                   ras_n,
   input logic                   cas_n,
   input logic                   we_n,
   input logic [BA_W-1:0]        ba,
   input logic                   a8,
   input logic [1:0]             verdict_o,
   input logic [3*NUM_BANKS-1:0] bank_state_o,
   input logic [2:0]             glob_state_o
);

   function automatic logic [2:0] fld(input logic [3*NUM_BANKS-1:0] v, input logic [BA_W-1:0] i);
      return v[3*i +: 3];
   endfunction

   function automatic logic none_open(input logic [3*NUM_BANKS-1:0] v);
      logic r = 1'b1;
      for (int b = 0; b < NUM_BANKS; b++)
         if (v[3*b +: 3] == 3'd2 || v[3*b +: 3] == 3'd3 || v[3*b +: 3] == 3'd4) r = 1'b0;
      return r;
   endfunction

   logic [3:0]      pins;
   logic            nopish;
   logic [BA_W-1:0] ba_q;
   int unsigned     open_cnt;

   assign pins   = {cs_n, ras_n, cas_n, we_n};
   assign nopish = cs_n || (pins == 4'b0111);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ba_q     <= '0;
         open_cnt <= 0;
      end else begin
         ba_q     <= ba;
         open_cnt <= (bank_state_o[2:0] == 3'd1) ? open_cnt + 1 : 0;
      end
   end

   // R2
   verdict_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_o != 2'd3);

   // R3
   act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && pins == 4'b0011 && verdict_o == 2'd1) |=> fld(bank_state_o, ba_q) == 3'd1);

   // R3
   open_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_state_o[2:0] == 3'd2 && $past(bank_state_o[2:0]) == 3'd1)
      |-> open_cnt == T_RCD - 1);

   // R6
   pall_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && pins == 4'b0010 && a8 && verdict_o == 2'd1) |=> none_open(bank_state_o));

   // R8
   mode_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (glob_state_o == 3'd1) |-> verdict_o != 2'd1);

   // R10
   sleep_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (glob_state_o == 3'd3 && !cke && !nopish) |-> verdict_o == 2'd2);

   // R12
   reject_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict_o == 2'd2 && glob_state_o == 3'd0 && fld(bank_state_o, ba) == 3'd2)
      |=> fld(bank_state_o, ba_q) == 3'd2);

endmodule

bind sdram_cmd_tracker sdcl_chk #(.NUM_BANKS(NUM_BANKS), .T_RCD(T_RCD)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cke         (cke),
   .cs_n        (cs_n),
   .ras_n       (ras_n),
   .cas_n       (cas_n),
   .we_n        (we_n),
   .ba          (ba),
   .a8          (a8),
   .verdict_o   (verdict_o),
   .bank_state_o(bank_state_o),
   .glob_state_o(glob_state_o)
);

// File: tb/sdram_cmd_tracker_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_tb_top;

   localparam int TRCD = 3, TRP = 3, TMRD = 2, TRFC = 6, TXSR = 4, TBST = 4;

   localparam logic [3:0] C_DSEL = 4'b1111, C_NOP = 4'b0111, C_BST = 4'b0110,
                          C_RD = 4'b0101, C_WR = 4'b0100, C_ACT = 4'b0011,
                          C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;
   localparam logic [1:0] V_NOP = 2'd0, V_OK = 2'd1, V_BAD = 2'd2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke = 1'b1;
   logic [3:0]  cmd4 = C_DSEL;
   logic [1:0]  ba = 2'd0;
   logic        a8 = 1'b0;
   logic [1:0]  verdict;
   logic [11:0] bstate;
   logic [2:0]  gstate;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   sdram_cmd_tracker #(.NUM_BANKS(4), .T_RCD(TRCD), .T_RP(TRP), .T_MRD(TMRD),
                       .T_RFC(TRFC), .T_XSR(TXSR), .BURST_CYC(TBST)) dut_i (
      .clk(clk), .rst_n(rst_n), .cke(cke),
      .cs_n(cmd4[3]), .ras_n(cmd4[2]), .cas_n(cmd4[1]), .we_n(cmd4[0]),
      .ba(ba), .a8(a8),
      .verdict_o(verdict), .bank_state_o(bstate), .glob_state_o(gstate)
   );

   task automatic step(input logic [3:0] c, input logic [1:0] b, input logic ap,
                       input logic ck, input logic [1:0] exp, input string tag);
      @(negedge clk);
      cmd4 = c; ba = b; a8 = ap; cke = ck;
      #1;
      n_run++;
      if (verdict !== exp) begin
         n_fail++;
         $display("FAIL %s verdict got %0d expected %0d", tag, verdict, exp);
      end
      @(posedge clk);
      #1;
   endtask

   task automatic nops(input int n, input string tag);
      for (int i = 0; i < n; i++) step(C_NOP, 2'd0, 1'b0, 1'b1, V_NOP, tag);
   endtask

   task automatic chk_bank(input int b, input logic [2:0] exp, input string tag);
      n_run++;
      if (bstate[3*b +: 3] !== exp) begin
         n_fail++;
         $display("FAIL %s bank%0d state got %0d expected %0d", tag, b, bstate[3*b +: 3], exp);
      end
   endtask

   task automatic chk_glob(input logic [2:0] exp, input string tag);
      n_run++;
      if (gstate !== exp) begin
         n_fail++;
         $display("FAIL %s device state got %0d expected %0d", tag, gstate, exp);
      end
   endtask

   task automatic t_idle();
      for (int b = 0; b < 4; b++) chk_bank(b, 3'd0, "R1 reset");
      chk_glob(3'd0, "R1 reset");
      step(C_NOP, 2'd0, 1'b0, 1'b1, V_NOP, "R2 nop");
      step(C_DSEL, 2'd0, 1'b0, 1'b1, V_NOP, "R2 deselect");
   endtask

   task automatic t_activate();
      step(C_ACT, 2'd1, 1'b0, 1'b1, V_OK, "R3 act");
      chk_bank(1, 3'd1, "R3 opening");
      nops(1, "R3 wait");
      step(C_RD, 2'd1, 1'b0, 1'b1, V_BAD, "R3 early read");
      chk_bank(1, 3'd2, "R3 open after tRCD");
      step(C_ACT, 2'd1, 1'b0, 1'b1, V_BAD, "R3 act to open bank");
      chk_bank(1, 3'd2, "R12 no change");
   endtask

   task automatic t_read();
      step(C_RD, 2'd1, 1'b0, 1'b1, V_OK, "R4 read");
      chk_bank(1, 3'd3, "R4 reading");
      step(C_WR, 2'd1, 1'b0, 1'b1, V_BAD, "R4 write in read");
      nops(2, "R4 burst");
      chk_bank(1, 3'd2, "R4 burst end");
      step(C_RD, 2'd1, 1'b1, 1'b1, V_OK, "R4 read autopre");
      nops(3, "R4 burst");
      chk_bank(1, 3'd5, "R4 autopre closing");
      nops(3, "R4 close");
      chk_bank(1, 3'd0, "R4 autopre idle");
      step(C_PRE, 2'd1, 1'b0, 1'b1, V_NOP, "R5 pre idle");
   endtask

   task automatic t_write_pre();
      step(C_ACT, 2'd0, 1'b0, 1'b1, V_OK, "R5 act");
      nops(2, "R5 wait");
      step(C_WR, 2'd0, 1'b0, 1'b1, V_OK, "R4 write");
      chk_bank(0, 3'd4, "R4 writing");
      step(C_PRE, 2'd0, 1'b0, 1'b1, V_OK, "R5 pre ends burst");
      chk_bank(0, 3'd5, "R5 closing");
      step(C_PRE, 2'd0, 1'b0, 1'b1, V_BAD, "R5 pre while closing");
      nops(1, "R5 close");
      chk_bank(0, 3'd0, "R5 idle after tRP");
   endtask

   task automatic t_pall();
      step(C_ACT, 2'd0, 1'b0, 1'b1, V_OK, "R6 act b0");
      step(C_ACT, 2'd3, 1'b0, 1'b1, V_OK, "R6 act b3");
      step(C_PRE, 2'd0, 1'b1, 1'b1, V_BAD, "R6 pall while opening");
      nops(1, "R6 wait");
      step(C_PRE, 2'd2, 1'b1, 1'b1, V_OK, "R6 pall");
      chk_bank(0, 3'd5, "R6 b0 closing");
      chk_bank(3, 3'd5, "R6 b3 closing");
      chk_bank(1, 3'd0, "R6 b1 untouched");
      nops(2, "R6 close");
      chk_bank(0, 3'd0, "R6 b0 idle");
      chk_bank(3, 3'd0, "R6 b3 idle");
      step(C_PRE, 2'd0, 1'b1, 1'b1, V_NOP, "R6 pall all idle");
   endtask

   task automatic t_bst();
      step(C_BST, 2'd0, 1'b0, 1'b1, V_BAD, "R7 bst no read");
      step(C_ACT, 2'd2, 1'b0, 1'b1, V_OK, "R7 act");
      nops(2, "R7 wait");
      step(C_RD, 2'd2, 1'b0, 1'b1, V_OK, "R7 read");
      step(C_BST, 2'd0, 1'b0, 1'b1, V_OK, "R7 bst");
      chk_bank(2, 3'd2, "R7 open after bst");
   endtask

   task automatic t_mrs();
      step(C_MRS, 2'd0, 1'b0, 1'b1, V_BAD, "R8 mrs bank open");
      chk_glob(3'd0, "R12 device unchanged");
      chk_bank(2, 3'd2, "R12 bank unchanged");
      step(C_PRE, 2'd2, 1'b0, 1'b1, V_OK, "R5 pre");
      nops(2, "R5 close");
      chk_bank(2, 3'd0, "R5 idle");
      step(C_MRS, 2'd0, 1'b0, 1'b1, V_OK, "R8 mrs");
      chk_glob(3'd1, "R8 mode window");
      step(C_ACT, 2'd0, 1'b0, 1'b1, V_BAD, "R8 act in window");
      chk_glob(3'd0, "R8 window end");
      chk_bank(0, 3'd0, "R12 bank unchanged");
   endtask

   task automatic t_aref();
      step(C_ACT, 2'd0, 1'b0, 1'b1, V_OK, "R9 act");
      step(C_REF, 2'd0, 1'b0, 1'b1, V_BAD, "R9 ref bank busy");
      nops(1, "R9 wait");
      step(C_PRE, 2'd0, 1'b0, 1'b1, V_OK, "R9 pre");
      nops(2, "R9 close");
      step(C_REF, 2'd0, 1'b0, 1'b1, V_OK, "R9 ref");
      chk_glob(3'd2, "R9 refresh");
      step(C_MRS, 2'd0, 1'b0, 1'b1, V_BAD, "R9 mrs in refresh");
      nops(4, "R9 refresh");
      chk_glob(3'd0, "R9 refresh end");
   endtask

   task automatic t_sref();
      step(C_REF, 2'd0, 1'b0, 1'b0, V_OK, "R10 sref entry");
      chk_glob(3'd3, "R10 self refresh");
      step(C_NOP, 2'd0, 1'b0, 1'b0, V_NOP, "R10 stay");
      step(C_ACT, 2'd0, 1'b0, 1'b0, V_BAD, "R10 act asleep");
      step(C_NOP, 2'd0, 1'b0, 1'b1, V_OK, "R10 exit");
      chk_glob(3'd4, "R10 exit window");
      step(C_ACT, 2'd0, 1'b0, 1'b1, V_BAD, "R10 act in exit");
      nops(2, "R10 exit");
      chk_glob(3'd0, "R10 normal");
   endtask

   task automatic t_pdown();
      step(C_NOP, 2'd0, 1'b0, 1'b0, V_OK, "R11 pdn entry");
      chk_glob(3'd5, "R11 power down");
      step(C_DSEL, 2'd0, 1'b0, 1'b0, V_NOP, "R11 stay");
      step(C_NOP, 2'd0, 1'b0, 1'b1, V_OK, "R11 exit");
      chk_glob(3'd0, "R11 normal");
      step(C_ACT, 2'd0, 1'b0, 1'b1, V_OK, "R11 act");
      nops(2, "R11 wait");
      step(C_NOP, 2'd0, 1'b0, 1'b0, V_BAD, "R11 pdn bank open");
      chk_glob(3'd0, "R11 no pdn");
      step(C_NOP, 2'd0, 1'b0, 1'b1, V_NOP, "R11 cke back");
      step(C_PRE, 2'd0, 1'b0, 1'b1, V_OK, "R11 pre");
      nops(2, "R11 close");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_idle();
      t_activate();
      t_read();
      t_write_pre();
      t_pall();
      t_bst();
      t_mrs();
      t_aref();
      t_sref();
      t_pdown();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog run did not complete");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule